// File: doc/BRIEF.md
# Ethernet Receive-Frame Fast-Path Classifier

This block watches the words of a received Ethernet frame as they stream past and sorts each frame into one of three destinations. Streaming sample data goes to the fast path. A small management frame that carries a new IP address is an address-recovery frame. Everything else goes to the CPU slow path. Each frame is held as 32-bit words. Two padding bytes come before the 14-byte Ethernet header, so the IP header starts on a word boundary at byte 16 and the UDP header starts at byte 36. The classifier does not validate whole headers. It looks at a few fixed word positions, and each test is cheap enough to decide at line rate.

Words enter on a valid/ready port, with start-of-frame and end-of-frame flags carried alongside each word. The block never applies back-pressure: `in_ready` is high whenever the block is out of reset, so the upstream buffer can empty at one word per cycle, and it may also leave gaps by dropping `in_valid`. After the end-of-frame word a verdict appears for one cycle. A recovery frame also loads its IP address with a strobe. A slow-path frame also reports a line count for the CPU handler. The UDP data port and the payload header value that marks a frame as not-data are configuration inputs.

Top module: `fpc_classifier`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `verdict_valid` and `ip_load` are low and `ip_addr` is zero.
- R2: Word k of a frame holds bytes 4k to 4k+3, and byte 4k sits in bits [31:24]. A frame is fast-path (verdict 3'b100) when bits [15:0] of word 9 equal `cfg_data_port` and word 11 differs from `cfg_bad_hdr`.
- R3: A frame whose word 11 equals `cfg_bad_hdr` is not fast-path, even when the port matches.
- R4: A frame that fails the fast test is a recovery frame (verdict 3'b010) when word 3 bits [15:0] are 16'hBEEE, word 4 is 32'h61646472 (ASCII "addr"), and word 5 is received. In the verdict cycle `ip_load` pulses and `ip_addr` takes word 5. `ip_addr` then holds until the next load.
- R5: The fast test has priority. A frame that passes both tests gets verdict 3'b100, and `ip_load` stays low.
- R6: Any other frame is slow-path (verdict 3'b001). `slow_len` equals the zero-based index of the end-of-frame word minus 3, with a floor of 0. `slow_len` is 0 with the other verdicts.
- R7: `verdict_valid` is high for exactly one cycle, the cycle after the end-of-frame word is accepted. `verdict` is 3'b000 whenever `verdict_valid` is low.
- R8: A frame that ends before word 11 cannot be fast-path. A frame that ends before word 5 cannot be recovery.
- R9: A start-of-frame word clears all captured state, including in the middle of an open frame. Words that arrive while no frame is open and carry no start flag are ignored and produce no verdict.
- R10: `in_ready` is high whenever the block is out of reset. Cycles with `in_valid` low do not advance the word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on `in_data` is valid |
| in_ready | output | 1 | Block accepts a word (high out of reset) |
| in_data | input | 32 | Frame word, first byte in bits [31:24] |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| cfg_data_port | input | 16 | UDP destination port of streaming data |
| cfg_bad_hdr | input | 32 | Payload header value that disqualifies fast path |
| verdict_valid | output | 1 | One-cycle verdict pulse |
| verdict | output | 3 | One-hot {fast, recovery, slow} |
| slow_len | output | IDX_W | Last word index minus 3, for slow-path frames |
| ip_load | output | 1 | Strobe: new recovery IP address |
| ip_addr | output | 32 | Last recovered IP address |

## Verification
The bench builds each frame so that the tests are turned on one at a time. A data frame with a good payload header and one with the invalid header tell the payload comparison apart from the port match. A recovery frame, a wrong ASCII tag and a frame that passes both tests check the ordering between recovery and fast path. Frames cut short at word 10 and at word 4 show that a test cannot be passed with fields the block never received. Gapped transfers, a start flag arriving mid-frame and stray words with no start flag check the index counting and the clearing of per-frame state.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // Word positions inside the padded frame buffer
  localparam int WORD_ETYPE = 3;
  localparam int WORD_TAG   = 4;
  localparam int WORD_IP    = 5;
  localparam int WORD_PORT  = 9;
  localparam int WORD_PAY   = 11;
  localparam int SLOW_BIAS  = 3;

  localparam logic [15:0] RECOVERY_ETYPE = 16'hBEEE;
  localparam logic [31:0] RECOVERY_TAG   = 32'h61646472;

  // one-hot verdict codes
  localparam logic [2:0] VD_NONE = 3'b000;
  localparam logic [2:0] VD_FAST = 3'b100;
  localparam logic [2:0] VD_RCV  = 3'b010;
  localparam logic [2:0] VD_SLOW = 3'b001;

  typedef struct packed {
    logic port_ok;
    logic pay_ok;
    logic etype_ok;
    logic tag_ok;
    logic ip_seen;
  } match_flags_t;
endpackage

// File: rtl/fpc_word_tracker.sv
module fpc_word_tracker #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  output logic             take,
  output logic             last_take,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             open_q;
  logic [IDX_W-1:0] next_q;

  assign take      = beat && (sof || open_q);
  assign last_take = take && eof;
  assign cur_idx   = sof ? '0 : next_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      next_q <= '0;
    end else if (take) begin
      open_q <= !eof;
      next_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
    end
  end

  // R9
  restart_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> (next_q == IDX_W'(1)));

  // R9
  stray_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !sof) |=> $stable(next_q));

  // R10
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(next_q) && $stable(open_q));
endmodule

// File: rtl/fpc_field_capture.sv
module fpc_field_capture
  import fpc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sof,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [31:0]      data,
  input  logic [15:0]      cfg_data_port,
  input  logic [31:0]      cfg_bad_hdr,
  output match_flags_t     flags_now,
  output logic [31:0]      ip_now
);
  localparam logic [IDX_W-1:0] I_ETYPE = IDX_W'(WORD_ETYPE);
  localparam logic [IDX_W-1:0] I_TAG   = IDX_W'(WORD_TAG);
  localparam logic [IDX_W-1:0] I_IP    = IDX_W'(WORD_IP);
  localparam logic [IDX_W-1:0] I_PORT  = IDX_W'(WORD_PORT);
  localparam logic [IDX_W-1:0] I_PAY   = IDX_W'(WORD_PAY);

  match_flags_t flags_q, base;
  logic [31:0]  ip_q, ip_base;

  // flags as seen after the current word is folded in
  always_comb begin
    base    = sof ? '0 : flags_q;
    ip_base = sof ? '0 : ip_q;
    flags_now = base;
    ip_now    = ip_base;
    if (take) begin
      if (cur_idx == I_ETYPE) flags_now.etype_ok = (data[15:0] == RECOVERY_ETYPE);
      if (cur_idx == I_TAG)   flags_now.tag_ok   = (data == RECOVERY_TAG);
      if (cur_idx == I_IP) begin
        flags_now.ip_seen = 1'b1;
        ip_now            = data;
      end
      if (cur_idx == I_PORT)  flags_now.port_ok  = (data[15:0] == cfg_data_port);
      if (cur_idx == I_PAY)   flags_now.pay_ok   = (data != cfg_bad_hdr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      ip_q    <= '0;
    end else if (take) begin
      flags_q <= flags_now;
      ip_q    <= ip_now;
    end
  end

  // R9
  fresh_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sof) |=> (flags_q == '0) && (ip_q == '0));

  // R8
  no_early_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sof) |=> !flags_q.pay_ok && !flags_q.port_ok && !flags_q.ip_seen);
endmodule

// File: rtl/fpc_verdict.sv
module fpc_verdict
  import fpc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  match_flags_t     flags,
  input  logic [IDX_W-1:0] last_idx,
  output logic [2:0]       code,
  output logic [IDX_W-1:0] len
);
  localparam logic [IDX_W-1:0] BIAS = IDX_W'(SLOW_BIAS);

  logic is_fast, is_rcv;

  assign is_fast = flags.port_ok && flags.pay_ok;
  assign is_rcv  = flags.etype_ok && flags.tag_ok && flags.ip_seen;

  always_comb begin
    len = '0;
    if (is_fast)     code = VD_FAST;
    else if (is_rcv) code = VD_RCV;
    else begin
      code = VD_SLOW;
      len  = (last_idx >= BIAS) ? last_idx - BIAS : '0;
    end
  end
endmodule

// File: rtl/fpc_classifier.sv
module fpc_classifier
  import fpc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [15:0]      cfg_data_port,
  input  logic [31:0]      cfg_bad_hdr,
  output logic             verdict_valid,
  output logic [2:0]       verdict,
  output logic [IDX_W-1:0] slow_len,
  output logic             ip_load,
  output logic [31:0]      ip_addr
);
  logic             ready_q;
  logic             take, last_take;
  logic [IDX_W-1:0] cur_idx;
  match_flags_t     flags_now;
  logic [31:0]      ip_now;
  logic [2:0]       code;
  logic [IDX_W-1:0] len;

  assign in_ready = ready_q;

  fpc_word_tracker #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .beat(in_valid && ready_q), .sof(in_sof), .eof(in_eof),
    .take(take), .last_take(last_take), .cur_idx(cur_idx)
  );

  fpc_field_capture #(.IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof),
    .cur_idx(cur_idx), .data(in_data),
    .cfg_data_port(cfg_data_port), .cfg_bad_hdr(cfg_bad_hdr),
    .flags_now(flags_now), .ip_now(ip_now)
  );

  fpc_verdict #(.IDX_W(IDX_W)) u_vd (
    .flags(flags_now), .last_idx(cur_idx), .code(code), .len(len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q       <= 1'b0;
      verdict_valid <= 1'b0;
      verdict       <= VD_NONE;
      slow_len      <= '0;
      ip_load       <= 1'b0;
      ip_addr       <= '0;
    end else begin
      ready_q       <= 1'b1;
      verdict_valid <= last_take;
      verdict       <= last_take ? code : VD_NONE;
      slow_len      <= last_take ? len : '0;
      ip_load       <= last_take && (code == VD_RCV);
      if (last_take && (code == VD_RCV)) ip_addr <= ip_now;
    end
  end

  // R7
  onehot_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> ($countones(verdict) == 1));

  // R7
  idle_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> (verdict == VD_NONE) && !ip_load);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !(in_valid && in_eof)) |=> !verdict_valid);

  // R4
  load_with_rcv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ip_load |-> verdict_valid && (verdict == VD_RCV));

  // R4
  ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ip_load |=> $stable(ip_addr) || ip_load);

  // R6
  len_only_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict[0] |-> (slow_len == '0));

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

// File: tb/tb_fpc_classifier.sv
module tb_fpc_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 10;
  localparam logic [15:0] PORT = 16'h1234;
  localparam logic [31:0] BAD  = 32'hDEAD0000;
  localparam logic [31:0] GOOD = 32'h1C000010;
  localparam logic [31:0] TAG  = 32'h61646472;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, verdict_valid, ip_load;
  logic [2:0] verdict;
  logic [IDX_W-1:0] slow_len;
  logic [31:0] ip_addr;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] fw [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  fpc_classifier #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .cfg_data_port(PORT), .cfg_bad_hdr(BAD),
    .verdict_valid(verdict_valid), .verdict(verdict), .slow_len(slow_len),
    .ip_load(ip_load), .ip_addr(ip_addr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic build(logic [15:0] port, logic [31:0] pay, logic [15:0] etype,
                       logic [31:0] tag, logic [31:0] ip);
    for (int i = 0; i < 64; i++) fw[i] = 32'h50000000 | i;
    fw[3]  = {16'h0000, etype};
    fw[4]  = tag;
    fw[5]  = ip;
    fw[9]  = {16'h0000, port};
    fw[11] = pay;
  endtask

  // drives words on negedges; returns on the negedge after the last word's edge
  task automatic send(int n, int gap, bit with_sof, bit close);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fw[i];
      in_sof = with_sof && (i == 0);
      in_eof = close && (i == n - 1);
      if (i < n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic expect_verdict(string req, logic [2:0] code, int len);
    chk(req, "verdict_valid", 32'(verdict_valid), 32'd1);
    chk(req, "verdict", 32'(verdict), 32'(code));
    chk(req, "slow_len", 32'(slow_len), 32'(len));
    @(negedge clk);
    chk("R7", "pulse ends", 32'(verdict_valid), 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", 32'(in_ready), 32'd0);
    chk("R1", "verdict_valid in reset", 32'(verdict_valid), 32'd0);
    chk("R1", "ip_load in reset", 32'(ip_load), 32'd0);
    chk("R1", "ip_addr in reset", ip_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_fast();
    build(PORT, GOOD, 16'h0800, 32'h0, 32'h0);
    send(16, 0, 1'b1, 1'b1);
    chk("R2", "no ip_load on fast", 32'(ip_load), 32'd0);
    expect_verdict("R2", 3'b100, 0);
  endtask

  task automatic t_bad_payload();
    build(PORT, BAD, 16'h0800, 32'h0, 32'h0);
    send(16, 0, 1'b1, 1'b1);
    expect_verdict("R3", 3'b001, 12);
  endtask

  task automatic t_recovery();
    build(16'h0000, GOOD, 16'hBEEE, TAG, 32'h0A000102);
    send(8, 0, 1'b1, 1'b1);
    chk("R4", "ip_load", 32'(ip_load), 32'd1);
    chk("R4", "ip_addr", ip_addr, 32'h0A000102);
    expect_verdict("R4", 3'b010, 0);
    chk("R4", "ip_load drops", 32'(ip_load), 32'd0);
    chk("R4", "ip_addr held", ip_addr, 32'h0A000102);
  endtask

  task automatic t_priority();
    build(PORT, GOOD, 16'hBEEE, TAG, 32'hC0A80001);
    send(12, 0, 1'b1, 1'b1);
    chk("R5", "no ip_load", 32'(ip_load), 32'd0);
    expect_verdict("R5", 3'b100, 0);
    chk("R5", "ip_addr unchanged", ip_addr, 32'h0A000102);
  endtask

  task automatic t_short();
    build(PORT, GOOD, 16'h0800, 32'h0, 32'h0);
    send(11, 0, 1'b1, 1'b1);
    expect_verdict("R8", 3'b001, 7);
    build(16'h0000, GOOD, 16'hBEEE, TAG, 32'h01020304);
    send(5, 0, 1'b1, 1'b1);
    chk("R8", "no ip_load short", 32'(ip_load), 32'd0);
    expect_verdict("R8", 3'b001, 1);
    send(2, 0, 1'b1, 1'b1);
    expect_verdict("R6", 3'b001, 0);
  endtask

  task automatic t_wrong_tag();
    build(16'h0000, GOOD, 16'hBEEE, 32'h61646473, 32'h01020304);
    send(8, 0, 1'b1, 1'b1);
    expect_verdict("R6", 3'b001, 4);
  endtask

  task automatic t_gaps();
    build(PORT, GOOD, 16'h0800, 32'h0, 32'h0);
    send(12, 2, 1'b1, 1'b1);
    expect_verdict("R10", 3'b100, 0);
  endtask

  task automatic t_restart_and_stray();
    build(PORT, GOOD, 16'h0800, 32'h0, 32'h0);
    send(12, 0, 1'b1, 1'b0);
    chk("R9", "no verdict without eof", 32'(verdict_valid), 32'd0);
    build(16'h0777, GOOD, 16'h0800, 32'h0, 32'h0);
    send(12, 0, 1'b1, 1'b1);
    expect_verdict("R9", 3'b001, 8);
    build(PORT, GOOD, 16'h0800, 32'h0, 32'h0);
    send(12, 0, 1'b0, 1'b1);
    chk("R9", "stray words no verdict", 32'(verdict_valid), 32'd0);
    @(negedge clk);
    chk("R9", "stray words no verdict later", 32'(verdict_valid), 32'd0);
    send(6, 0, 1'b1, 1'b1);
    expect_verdict("R9", 3'b001, 2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_fast();
    t_bad_payload();
    t_recovery();
    t_priority();
    t_short();
    t_wrong_tag();
    t_gaps();
    t_restart_and_stray();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule